// File: doc/BRIEF.md
# Fill-Driven Oscillator Trim Controller

This block separates the timing of an incoming audio sample stream from the clock that plays it out. Samples enter a small buffer at whatever rate the source delivers them. They leave on read strobes that come from a locally generated, pullable clock. The block never measures the phase of the input. Instead it integrates the buffer occupancy over a long, fixed window and compares the mean against the buffer midpoint, with a tolerance band of two words. Only when the mean leaves that band does it move a signed oscillator trim word by one LSB, which represents a tiny fractional frequency change. Short-term input jitter therefore never reaches the playback clock. The loop only drifts the clock slowly enough to keep the buffer from running full or dry.

Two lock modes exist. Narrow mode uses a long averaging window and a small trim range. Wide mode, for varispeed sources, uses a much shorter window and a much larger trim range. A mode request is honoured only while an input signal is present. When the input is lost, the buffer is re-centred at half depth with zero-valued padding and the error flags clear. Writes and reads are ignored while the input is absent, and the trim word holds its value.

Top module: `fill_trim_ctrl`

## Requirements
- R1: After reset the buffer holds DEPTH/2 padding words, the trim word is 0, narrow mode is selected, and both error flags are clear.
- R2: A read strobe on a non-empty buffer returns, one cycle later with rd_valid high, first any remaining zero padding words and then the written words in write order. A simultaneous read and write are both accepted.
- R3: A write while the buffer holds DEPTH words, with no read in the same cycle, is dropped and raises the overflow flag. The flag stays set until reset or loss of input.
- R4: A read strobe on an empty buffer produces no rd_valid and raises the underflow flag. The flag stays set until reset or loss of input.
- R5: At the end of each averaging window (2^NARROW_LOG2 cycles in narrow mode, 2^WIDE_LOG2 in wide mode), the floor of the mean fill is compared with DEPTH/2. The trim rises by one if the mean is above DEPTH/2+2 and falls by one if it is below DEPTH/2-2. A mean equal to DEPTH/2+2 or DEPTH/2-2 leaves the trim unchanged.
- R6: Outside a mode change, the trim word moves by at most one LSB, and successive moves are at least one averaging window of the current mode apart.
- R7: The trim word saturates at +/-NARROW_LIM in narrow mode and at +/-WIDE_LIM in wide mode.
- R8: wide_req is adopted on the next edge only while sig_present is high. A change of mode restarts the averaging window. Entering narrow mode clamps the trim word to +/-NARROW_LIM.
- R9: While sig_present is low, the buffer is held at DEPTH/2 padding words and both flags clear. Writes and reads are ignored, and the trim word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_present | input | 1 | High while a valid input stream is present |
| wide_req | input | 1 | Requested lock mode: 1 wide, 0 narrow |
| wr_en | input | 1 | Write one incoming sample |
| wr_data | input | DW | Incoming sample |
| rd_en | input | 1 | Read strobe from the local playback clock |
| rd_data | output | DW | Sample returned for the previous read strobe |
| rd_valid | output | 1 | rd_data holds a sample read in the previous cycle |
| fill_level | output | log2(DEPTH)+1 | Current buffer occupancy in words |
| trim_word | output | TW | Signed oscillator trim, one LSB per step |
| wide_mode | output | 1 | Current lock mode: 1 wide |
| overflow | output | 1 | Sticky: a write was dropped on a full buffer |
| underflow | output | 1 | Sticky: a read hit an empty buffer |

## Verification
The hardest situation to reach is a trim step that happens, or fails to happen, exactly at a deadband edge. Such a step is only visible after whole averaging windows, and saturation can hide it. The stimulus parks the fill at an exact level with plain writes and reads, then watches the trim every cycle across several windows. It approaches each deadband edge from the side where a wrong step in the other direction cannot be absorbed by saturation. The same per-cycle watch measures the spacing between steps in both modes, and drives the trim into each mode's limit and back through the narrow-mode clamp.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

    typedef enum logic {
        LOCK_NARROW = 1'b0,
        LOCK_WIDE   = 1'b1
    } lock_mode_e;

    // Limit a signed value to the symmetric range [-lim, +lim].
    function automatic int clamp_sym(input int v, input int lim);
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

endpackage

// File: rtl/ftc_fifo.sv
module ftc_fifo #(
    parameter int DW    = 24,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr_en,
    input  logic [DW-1:0]              wr_data,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_data,
    output logic                       rd_valid,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       ovf,
    output logic                       udf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic [CW-1:0] pad;
        logic [DW-1:0] rdat;
        logic          rvld;
        logic          ovf;
        logic          udf;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_rd, do_wr;

    always_comb begin
        st_d  = st_q;
        do_rd = rd_en && (st_q.cnt != '0) && !clear;
        do_wr = wr_en && !clear && ((st_q.cnt != FULL_C) || do_rd);
        if (clear) begin
            // Re-centre: half depth of zero padding ahead of the write pointer.
            st_d.rp   = st_q.wp;
            st_d.cnt  = HALF_C;
            st_d.pad  = HALF_C;
            st_d.rvld = 1'b0;
            st_d.rdat = '0;
            st_d.ovf  = 1'b0;
            st_d.udf  = 1'b0;
        end else begin
            st_d.rvld = do_rd;
            if (do_rd) begin
                if (st_q.pad != '0) begin
                    st_d.rdat = '0;
                    st_d.pad  = st_q.pad - 1'b1;
                end else begin
                    st_d.rdat = mem_q[st_q.rp];
                    st_d.rp   = st_q.rp + 1'b1;
                end
            end
            if (do_wr) begin
                st_d.wp = st_q.wp + 1'b1;
            end
            if (rd_en && (st_q.cnt == '0)) begin
                st_d.udf = 1'b1;
            end
            if (wr_en && (st_q.cnt == FULL_C) && !do_rd) begin
                st_d.ovf = 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(do_wr) - CW'(do_rd);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cnt  <= HALF_C;
            st_q.pad  <= HALF_C;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_q[st_q.wp] <= wr_data;
        end
    end

    assign rd_data  = st_q.rdat;
    assign rd_valid = st_q.rvld;
    assign level    = st_q.cnt;
    assign ovf      = st_q.ovf;
    assign udf      = st_q.udf;

endmodule

// File: rtl/ftc_fill_avg.sv
module ftc_fill_avg #(
    parameter int LVL_W       = 7,
    parameter int NARROW_LOG2 = 20,
    parameter int WIDE_LOG2   = 14,
    parameter int TARGET      = 32,
    parameter int BAND        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wide,
    input  logic [LVL_W-1:0] level,
    output logic             step_up,
    output logic             step_dn
);
    localparam int CNT_W = (NARROW_LOG2 > WIDE_LOG2) ? NARROW_LOG2 : WIDE_LOG2;
    localparam int ACC_W = LVL_W + CNT_W;
    localparam logic [CNT_W-1:0] N_LAST = CNT_W'((64'd1 << NARROW_LOG2) - 64'd1);
    localparam logic [CNT_W-1:0] W_LAST = CNT_W'((64'd1 << WIDE_LOG2) - 64'd1);
    localparam logic [ACC_W-1:0] HI_TH  = ACC_W'(TARGET + BAND);
    localparam logic [ACC_W-1:0] LO_TH  = ACC_W'(TARGET - BAND);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
    } avg_st_t;

    avg_st_t st_q, st_d;
    logic [ACC_W-1:0] sum, mean;
    logic             last;

    always_comb begin
        st_d = st_q;
        sum  = st_q.acc + ACC_W'(level);
        last = wide ? (st_q.cnt == W_LAST) : (st_q.cnt == N_LAST);
        mean = wide ? (sum >> WIDE_LOG2) : (sum >> NARROW_LOG2);
        step_up = 1'b0;
        step_dn = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
            st_d.acc = '0;
        end else if (last) begin
            step_up  = (mean > HI_TH);
            step_dn  = (mean < LO_TH);
            st_d.cnt = '0;
            st_d.acc = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.acc = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ftc_trim_ctrl.sv
module ftc_trim_ctrl
    import ftc_pkg::*;
#(
    parameter int TW         = 16,
    parameter int NARROW_LIM = 1500,
    parameter int WIDE_LIM   = 32767
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sig_present,
    input  logic                 wide_req,
    input  logic                 step_up,
    input  logic                 step_dn,
    output logic                 mode_chg,
    output logic                 wide,
    output logic signed [TW-1:0] trim
);
    typedef struct packed {
        lock_mode_e            mode;
        logic signed [TW-1:0]  trim;
    } trim_st_t;

    trim_st_t st_q, st_d;
    lock_mode_e req_mode;
    int cur_i, lim_i, nxt_i;

    always_comb begin
        st_d     = st_q;
        req_mode = wide_req ? LOCK_WIDE : LOCK_NARROW;
        mode_chg = sig_present && (req_mode != st_q.mode);
        cur_i    = int'(st_q.trim);
        lim_i    = (st_q.mode == LOCK_WIDE) ? WIDE_LIM : NARROW_LIM;
        nxt_i    = cur_i;
        if (mode_chg) begin
            st_d.mode = req_mode;
            if (req_mode == LOCK_NARROW) begin
                nxt_i = clamp_sym(cur_i, NARROW_LIM);
            end
        end else if (step_up) begin
            nxt_i = clamp_sym(cur_i + 1, lim_i);
        end else if (step_dn) begin
            nxt_i = clamp_sym(cur_i - 1, lim_i);
        end
        st_d.trim = nxt_i[TW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= LOCK_NARROW;
            st_q.trim <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wide = (st_q.mode == LOCK_WIDE);
    assign trim = st_q.trim;

endmodule

// File: rtl/fill_trim_ctrl.sv
module fill_trim_ctrl #(
    parameter int DW          = 24,
    parameter int DEPTH       = 64,
    parameter int TW          = 16,
    parameter int NARROW_LOG2 = 20,
    parameter int WIDE_LOG2   = 14,
    parameter int NARROW_LIM  = 1500,
    parameter int WIDE_LIM    = 32767,
    parameter int BAND        = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sig_present,
    input  logic                       wide_req,
    input  logic                       wr_en,
    input  logic [DW-1:0]              wr_data,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_data,
    output logic                       rd_valid,
    output logic [$clog2(DEPTH):0]     fill_level,
    output logic signed [TW-1:0]       trim_word,
    output logic                       wide_mode,
    output logic                       overflow,
    output logic                       underflow
);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    logic loss;
    logic mode_chg;
    logic avg_clear;
    logic step_up, step_dn;

    assign loss      = !sig_present;
    assign avg_clear = loss || mode_chg;

    ftc_fifo #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (loss),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .level    (fill_level),
        .ovf      (overflow),
        .udf      (underflow)
    );

    ftc_fill_avg #(
        .LVL_W       (LVL_W),
        .NARROW_LOG2 (NARROW_LOG2),
        .WIDE_LOG2   (WIDE_LOG2),
        .TARGET      (DEPTH / 2),
        .BAND        (BAND)
    ) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (avg_clear),
        .wide    (wide_mode),
        .level   (fill_level),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    ftc_trim_ctrl #(
        .TW         (TW),
        .NARROW_LIM (NARROW_LIM),
        .WIDE_LIM   (WIDE_LIM)
    ) u_trim (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_present (sig_present),
        .wide_req    (wide_req),
        .step_up     (step_up),
        .step_dn     (step_dn),
        .mode_chg    (mode_chg),
        .wide        (wide_mode),
        .trim        (trim_word)
    );

endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
    parameter int DEPTH       = 64,
    parameter int TW          = 16,
    parameter int NARROW_LOG2 = 20,
    parameter int WIDE_LOG2   = 14,
    parameter int NARROW_LIM  = 1500,
    parameter int WIDE_LIM    = 32767
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sig_present,
    input logic                   rd_en,
    input logic                   rd_valid,
    input logic [$clog2(DEPTH):0] fill_level,
    input logic signed [TW-1:0]   trim_word,
    input logic                   wide_mode,
    input logic                   overflow,
    input logic                   underflow
);
    localparam int GAP_SAT = 1 << 30;

    logic signed [TW-1:0] prev_trim_q;
    logic                 prev_wide_q;
    int                   gap_q;
    logic                 trim_moved;
    int                   win_m1;

    assign trim_moved = (trim_word != prev_trim_q);
    assign win_m1     = wide_mode ? ((1 << WIDE_LOG2) - 1) : ((1 << NARROW_LOG2) - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_trim_q <= '0;
            prev_wide_q <= 1'b0;
            gap_q       <= GAP_SAT;
        end else begin
            prev_trim_q <= trim_word;
            prev_wide_q <= wide_mode;
            if (trim_moved || (wide_mode != prev_wide_q)) begin
                gap_q <= 0;
            end else if (gap_q < GAP_SAT) begin
                gap_q <= gap_q + 1;
            end
        end
    end

    p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= ($clog2(DEPTH)+1)'(DEPTH));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && sig_present) |=> overflow);

    p_udf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && sig_present) |=> underflow);

    p_rdvalid_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_en) && $past(sig_present)));

    p_trim_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode == $past(wide_mode)) |->
        ((int'(trim_word) - int'($past(trim_word)) <= 1) &&
         (int'(trim_word) - int'($past(trim_word)) >= -1)));

    p_trim_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_moved && (wide_mode == prev_wide_q)) |-> (gap_q >= win_m1));

    p_trim_lim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode) |-> ((int'(trim_word) <= NARROW_LIM) && (int'(trim_word) >= -NARROW_LIM)));

    p_wide_lim_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wide_mode |-> ((int'(trim_word) <= WIDE_LIM) && (int'(trim_word) >= -WIDE_LIM)));

    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_present) |=> $stable(wide_mode));

    p_loss_centre_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_present) |=> ((fill_level == ($clog2(DEPTH)+1)'(DEPTH / 2)) && !overflow && !underflow));

    p_loss_trim_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_present) |=> $stable(trim_word));

endmodule

bind fill_trim_ctrl ftc_checker #(
    .DEPTH       (DEPTH),
    .TW          (TW),
    .NARROW_LOG2 (NARROW_LOG2),
    .WIDE_LOG2   (WIDE_LOG2),
    .NARROW_LIM  (NARROW_LIM),
    .WIDE_LIM    (WIDE_LIM)
) u_ftc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sig_present (sig_present),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .fill_level  (fill_level),
    .trim_word   (trim_word),
    .wide_mode   (wide_mode),
    .overflow    (overflow),
    .underflow   (underflow)
);

// File: tb/fill_trim_ctrl_bench.sv
`timescale 1ns/1ps
module fill_trim_ctrl_bench;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int TW    = 16;
    localparam int NL2   = 6;
    localparam int WL2   = 4;
    localparam int NLIM  = 5;
    localparam int WLIM  = 40;
    localparam int NWIN  = 1 << NL2;
    localparam int WWIN  = 1 << WL2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_present = 1'b1;
    logic wide_req = 1'b0;
    logic wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic rd_valid;
    logic [$clog2(DEPTH):0] fill_level;
    logic signed [TW-1:0] trim_word;
    logic wide_mode, overflow, underflow;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] model_q[$];
    logic [DW-1:0] exp_rd[$];
    logic [DW-1:0] data_seq = 16'h0100;

    always #2.5 clk = ~clk;

    fill_trim_ctrl #(
        .DW(DW), .DEPTH(DEPTH), .TW(TW), .NARROW_LOG2(NL2), .WIDE_LOG2(WL2),
        .NARROW_LIM(NLIM), .WIDE_LIM(WLIM), .BAND(2)
    ) u_fill_trim_ctrl (
        .clk(clk), .rst_n(rst_n), .sig_present(sig_present), .wide_req(wide_req),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .fill_level(fill_level), .trim_word(trim_word),
        .wide_mode(wide_mode), .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic centre_model();
        model_q.delete();
        for (int i = 0; i < DEPTH / 2; i++) model_q.push_back('0);
    endtask

    // Driver: one cycle of traffic, updating the reference queue.
    task automatic cyc(input bit wr, input bit rd);
        bit did_rd;
        @(negedge clk);
        wr_en = wr;
        rd_en = rd;
        wr_data = data_seq;
        did_rd = 1'b0;
        if (rd && model_q.size() > 0) begin
            exp_rd.push_back(model_q.pop_front());
            did_rd = 1'b1;
        end
        if (wr && (model_q.size() < DEPTH || did_rd)) model_q.push_back(data_seq);
        if (wr) data_seq = data_seq + 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            rd_en = 1'b0;
        end
    endtask

    task automatic set_level(input int target);
        while (model_q.size() < target) cyc(1'b1, 1'b0);
        while (model_q.size() > target) cyc(1'b0, 1'b1);
        idle(1);
    endtask

    task automatic watch(input int n, output int chg, output int mingap, output int fin);
        logic signed [TW-1:0] prev;
        int last;
        prev = trim_word;
        last = -1;
        chg = 0;
        mingap = 1 << 30;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (trim_word != prev) begin
                if (last >= 0 && (i - last) < mingap) mingap = i - last;
                last = i;
                chg++;
                prev = trim_word;
            end
        end
        fin = int'(trim_word);
    endtask

    task automatic drop_input(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sig_present = 1'b0;
            wr_en = 1'b1;
            rd_en = 1'b1;
            wr_data = 16'hDEAD;
            wide_req = 1'b1;
        end
        centre_model();
        @(negedge clk);
        sig_present = 1'b1;
        wr_en = 1'b0;
        rd_en = 1'b0;
        wide_req = 1'b0;
    endtask

    // Monitor: compares every returned sample with the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid) begin
                if (exp_rd.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R2 unexpected rd_valid actual=%0d expected=none", rd_data);
                end else begin
                    chk("R2 read data", rd_data, exp_rd.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 run did not finish actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int chg, gap, fin;
        centre_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 fill", fill_level, DEPTH / 2);
        chk("R1 trim", trim_word, 0);
        chk("R1 mode", wide_mode, 0);
        chk("R1 flags", {overflow, underflow}, 0);

        // R2 padding then data order, mixed patterns
        cyc(1'b0, 1'b1); cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1);
        for (int i = 0; i < 7; i++) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0); cyc(1'b0, 1'b1); cyc(1'b1, 1'b1);
        idle(2);
        chk("R2 fill after traffic", fill_level, model_q.size());

        // R5/R7 narrow: high fill drives trim up to the narrow limit, R6 spacing
        set_level(13);
        watch(10 * NWIN, chg, gap, fin);
        chk("R7 narrow upper limit", fin, NLIM);
        chk("R5 up step count", chg, NLIM);
        chk("R6 narrow spacing", gap >= NWIN, 1);

        // R5 deadband low edge (mid-2) from a saturated-high trim
        set_level(6);
        watch(5 * NWIN, chg, gap, fin);
        chk("R5 deadband low edge", chg, 0);

        // R5 low fill drives trim down to -limit
        set_level(3);
        watch(13 * NWIN, chg, gap, fin);
        chk("R7 narrow lower limit", fin, -NLIM);
        chk("R5 down step count", chg, 2 * NLIM);

        // R5 deadband high edge (mid+2) from a saturated-low trim
        set_level(10);
        watch(5 * NWIN, chg, gap, fin);
        chk("R5 deadband high edge", chg, 0);

        // R8 enter wide mode, R7 wide limit, R6 wide spacing
        @(negedge clk); wide_req = 1'b1;
        idle(1);
        chk("R8 wide adopted", wide_mode, 1);
        set_level(14);
        watch(900, chg, gap, fin);
        chk("R7 wide upper limit", fin, WLIM);
        chk("R6 wide spacing", gap >= WWIN, 1);

        // R8 back to narrow clamps trim
        set_level(8);
        @(negedge clk); wide_req = 1'b0;
        idle(1);
        chk("R8 narrow adopted", wide_mode, 0);
        chk("R8 narrow clamp", trim_word, NLIM);

        // R9 loss of input: ignored traffic, mode request ignored, trim held
        set_level(12);
        drop_input(20);
        idle(1);
        chk("R9 fill centred", fill_level, DEPTH / 2);
        chk("R8 mode held during loss", wide_mode, 0);
        chk("R9 trim held", trim_word, NLIM);

        // R3 overflow
        set_level(DEPTH);
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b0);
        idle(1);
        chk("R3 overflow flag", overflow, 1);
        chk("R3 fill full", fill_level, DEPTH);

        // R4 underflow
        set_level(0);
        cyc(1'b0, 1'b1);
        idle(2);
        chk("R4 underflow flag", underflow, 1);
        chk("R3 overflow sticky", overflow, 1);
        chk("R4 fill empty", fill_level, 0);

        // R9 flags cleared by loss
        drop_input(1);
        idle(1);
        chk("R9 flags cleared", {overflow, underflow}, 0);
        chk("R9 fill recentred", fill_level, DEPTH / 2);
        set_level(0);
        idle(3);
        chk("R2 scoreboard drained", exp_rd.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule